// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Triggers

This block is a bank of general-purpose pins behind a small word-wide register port. Software chooses a direction for each pin and drives its output value. It can write the whole output word at once, or raise or lower chosen bits with one-hot writes that leave the other bits alone. The pad-side inputs are resynchronised into the clock domain and can be read back as a word.

Every pin also has an interrupt detector. Three independent per-pin configuration words choose its trigger condition:

- a method word selects edge or level detection;
- a both-edges word lets any transition fire;
- a type word picks the polarity.

Detected events land in a raw status word. Edge events are held until software acknowledges them with a write-one-to-clear. Level conditions are tracked live. The raw status is gated by an enable word and a mask word to form the masked status, and any set masked bit raises the single bank interrupt line.

The pads, their tri-state drivers and any downstream interrupt controller sit outside the block. The block only presents output-enable, output-value and input vectors.

Top module: `gpio_irq_bank`

## Requirements
- R1: A write to byte offset 0x00 loads the output data word. It reads back at 0x00 and appears on `pad_out` from the clock edge that takes the write.
- R2: A write to offset 0x10 drives high every output bit written as 1 and leaves bits written as 0 unchanged. A write of all zeros changes nothing.
- R3: A write to offset 0x14 drives low every output bit written as 1 and leaves bits written as 0 unchanged.
- R4: Offset 0x08 holds the direction word. A bit of 1 makes the pin an output: `pad_oe` is 1 for that pin. A bit of 0 makes it an input. The word reads back at 0x08.
- R5: Offset 0x04 reads the pad inputs after a two-flop synchroniser, so a pad change becomes visible after the second rising clock edge. Writes to 0x04 are ignored.
- R6: A method bit of 0 (offset 0x34) selects edge detection. With the both-edges bit (offset 0x38) at 0, a type bit (offset 0x3C) of 0 fires on a rising edge and 1 fires on a falling edge. The raw status bit (offset 0x24) sets on the third rising clock edge after the pad change.
- R7: In edge mode, a both-edges bit of 1 fires on any transition whatever the type bit holds.
- R8: A method bit of 1 selects level detection, with a type bit of 0 meaning active-high and 1 meaning active-low. In this mode the raw status bit follows the live synchronised condition, and an acknowledge has no lasting effect while the level persists.
- R9: An edge-mode raw status bit stays set until a 1 is written to that bit at offset 0x30. Writing 0 there leaves every raw status bit unchanged.
- R10: The masked status at offset 0x28 equals raw AND enable (offset 0x20) AND NOT mask (offset 0x2C). `irq_out` is 1 exactly when any masked status bit is 1.
- R11: After reset every register reads 0 and every pin is an input. The write-only offsets 0x10, 0x14 and 0x30, and every offset outside the map, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address; bits [1:0] are ignored |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational from the address |
| pad_in | input | NPINS (32) | Pad input levels |
| pad_oe | output | NPINS (32) | Output enable per pin |
| pad_out | output | NPINS (32) | Output value per pin |
| irq_out | output | 1 | Bank interrupt |

## Verification
A wrong trigger decode or a lost edge reference shows up as a raw status bit that differs from the one the selected mode predicts. This is visible at offset 0x24 on the third clock edge after the pad change, so the bench sweeps every trigger mode against many pad patterns. Wrong sticky or acknowledge behaviour appears on the first read after an acknowledge write. A gating error in enable or mask shows at the same moment on both the masked-status read and `irq_out`. Output-side state is visible on `pad_out` and `pad_oe` one edge after the write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register byte offsets (software decodes these)
  localparam logic [7:0] OFF_DOUT   = 8'h00;
  localparam logic [7:0] OFF_DIN    = 8'h04;
  localparam logic [7:0] OFF_DIR    = 8'h08;
  localparam logic [7:0] OFF_SET    = 8'h10;
  localparam logic [7:0] OFF_CLR    = 8'h14;
  localparam logic [7:0] OFF_IEN    = 8'h20;
  localparam logic [7:0] OFF_RAW    = 8'h24;
  localparam logic [7:0] OFF_MSKD   = 8'h28;
  localparam logic [7:0] OFF_IMASK  = 8'h2C;
  localparam logic [7:0] OFF_ACK    = 8'h30;
  localparam logic [7:0] OFF_METH   = 8'h34;
  localparam logic [7:0] OFF_BOTH   = 8'h38;
  localparam logic [7:0] OFF_TYPE   = 8'h3C;

  // Trigger condition for one pin: meth=1 level, else edge.
  function automatic logic trig_hit(input logic meth, input logic both,
                                    input logic typ, input logic cur,
                                    input logic prev);
    logic hit;
    if (meth)      hit = typ ? ~cur : cur;
    else if (both) hit = cur ^ prev;
    else if (typ)  hit = prev & ~cur;
    else           hit = cur & ~prev;
    return hit;
  endfunction

  // Next raw status: level tracks live, edge is sticky until acknowledged.
  function automatic logic raw_next(input logic meth, input logic raw,
                                    input logic hit, input logic ack);
    return meth ? hit : ((raw & ~ack) | hit);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] d_in,
  output logic [NPINS-1:0] d_sync
);
  logic [NPINS-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/gpio_pin_trig.sv
module gpio_pin_trig
  import gpio_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  input  logic meth,
  input  logic both,
  input  logic typ,
  input  logic ack,
  output logic hit,
  output logic raw
);
  logic prev;

  assign hit = trig_hit(meth, both, typ, cur, prev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      raw  <= 1'b0;
    end else begin
      prev <= cur;
      raw  <= raw_next(meth, raw, hit, ack);
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic             irq_out
);
  localparam logic [AW-1:0] WORD_MASK = ~AW'(3);

  logic [AW-1:0]    waddr;
  logic [NPINS-1:0] wd;
  logic             wr_en;
  logic wr_dout, wr_set, wr_clr, wr_dir, wr_ien, wr_mask;
  logic wr_ack, wr_meth, wr_both, wr_type;

  logic [NPINS-1:0] r_dout, r_dir, r_ien, r_imask, r_meth, r_both, r_type;
  logic [NPINS-1:0] sync_vec, hit_vec, raw_vec, ack_vec, msk_vec;

  assign waddr = bus_addr & WORD_MASK;
  assign wd    = bus_wdata[NPINS-1:0];
  assign wr_en = bus_sel & bus_wr;

  assign wr_dout = wr_en && (waddr == AW'(OFF_DOUT));
  assign wr_set  = wr_en && (waddr == AW'(OFF_SET));
  assign wr_clr  = wr_en && (waddr == AW'(OFF_CLR));
  assign wr_dir  = wr_en && (waddr == AW'(OFF_DIR));
  assign wr_ien  = wr_en && (waddr == AW'(OFF_IEN));
  assign wr_mask = wr_en && (waddr == AW'(OFF_IMASK));
  assign wr_ack  = wr_en && (waddr == AW'(OFF_ACK));
  assign wr_meth = wr_en && (waddr == AW'(OFF_METH));
  assign wr_both = wr_en && (waddr == AW'(OFF_BOTH));
  assign wr_type = wr_en && (waddr == AW'(OFF_TYPE));

  assign ack_vec = wr_ack ? wd : '0;

  // Control registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_dout  <= '0;
      r_dir   <= '0;
      r_ien   <= '0;
      r_imask <= '0;
      r_meth  <= '0;
      r_both  <= '0;
      r_type  <= '0;
    end else begin
      if (wr_dout)     r_dout <= wd;
      else if (wr_set) r_dout <= r_dout | wd;
      else if (wr_clr) r_dout <= r_dout & ~wd;
      if (wr_dir)  r_dir   <= wd;
      if (wr_ien)  r_ien   <= wd;
      if (wr_mask) r_imask <= wd;
      if (wr_meth) r_meth  <= wd;
      if (wr_both) r_both  <= wd;
      if (wr_type) r_type  <= wd;
    end
  end

  gpio_in_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   (pad_in),
    .d_sync (sync_vec)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_pin_trig u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   (sync_vec[i]),
      .meth  (r_meth[i]),
      .both  (r_both[i]),
      .typ   (r_type[i]),
      .ack   (ack_vec[i]),
      .hit   (hit_vec[i]),
      .raw   (raw_vec[i])
    );
  end

  assign msk_vec = raw_vec & r_ien & ~r_imask;
  assign irq_out = |msk_vec;
  assign pad_oe  = r_dir;
  assign pad_out = r_dout;

  // Read mux; write-only and undefined offsets read zero
  always_comb begin
    bus_rdata = '0;
    unique case (waddr)
      AW'(OFF_DOUT):  bus_rdata[NPINS-1:0] = r_dout;
      AW'(OFF_DIN):   bus_rdata[NPINS-1:0] = sync_vec;
      AW'(OFF_DIR):   bus_rdata[NPINS-1:0] = r_dir;
      AW'(OFF_IEN):   bus_rdata[NPINS-1:0] = r_ien;
      AW'(OFF_RAW):   bus_rdata[NPINS-1:0] = raw_vec;
      AW'(OFF_MSKD):  bus_rdata[NPINS-1:0] = msk_vec;
      AW'(OFF_IMASK): bus_rdata[NPINS-1:0] = r_imask;
      AW'(OFF_METH):  bus_rdata[NPINS-1:0] = r_meth;
      AW'(OFF_BOTH):  bus_rdata[NPINS-1:0] = r_both;
      AW'(OFF_TYPE):  bus_rdata[NPINS-1:0] = r_type;
      default:        bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_out,
  input logic             irq_out,
  input logic [NPINS-1:0] sync_vec,
  input logic [NPINS-1:0] hit_vec,
  input logic [NPINS-1:0] raw_vec,
  input logic [NPINS-1:0] ack_vec,
  input logic [NPINS-1:0] r_meth,
  input logic [NPINS-1:0] r_ien,
  input logic [NPINS-1:0] r_imask
);
  logic [AW-3:0] wa;
  logic [1:0]    cyc;
  logic          defined;

  assign wa = bus_addr[AW-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n)        cyc <= '0;
    else if (cyc != 3) cyc <= cyc + 2'd1;
  end

  always_comb begin
    defined = 1'b0;
    case (wa)
      (AW-2)'(0), (AW-2)'(1), (AW-2)'(2), (AW-2)'(8), (AW-2)'(9),
      (AW-2)'(10), (AW-2)'(11), (AW-2)'(13), (AW-2)'(14), (AW-2)'(15):
        defined = 1'b1;
      default: defined = 1'b0;
    endcase
  end

  a_r2_set_ors_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && wa == (AW-2)'(4)) |=>
      pad_out == ($past(pad_out) | $past(bus_wdata[NPINS-1:0])));

  a_r3_clear_ands_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && wa == (AW-2)'(5)) |=>
      pad_out == ($past(pad_out) & ~$past(bus_wdata[NPINS-1:0])));

  a_r4_dir_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && wa == (AW-2)'(2)) |=>
      pad_oe == $past(bus_wdata[NPINS-1:0]));

  a_r5_two_flop_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 3) |-> sync_vec == $past(pad_in, 2));

  a_r6_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0) |-> ((hit_vec & ~r_meth & ~($past(sync_vec) ^ sync_vec)) == '0));

  a_r9_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(raw_vec & ~r_meth & ~ack_vec) & ~raw_vec) == '0);

  a_r10_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && wa == (AW-2)'(10)) |->
      (bus_rdata[NPINS-1:0] == (raw_vec & r_ien & ~r_imask)) &&
      (irq_out == (|bus_rdata)));

  a_r11_undefined_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !defined) |-> bus_rdata == '0);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .irq_out   (irq_out),
  .sync_vec  (sync_vec),
  .hit_vec   (hit_vec),
  .raw_vec   (raw_vec),
  .ack_vec   (ack_vec),
  .r_meth    (r_meth),
  .r_ien     (r_ien),
  .r_imask   (r_imask)
);

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/100ps
module gpio_irq_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe, pad_out;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // Called at a negedge; finishes before the next posedge
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    #0.5 bus_sel = 1'b0;
  endtask

  // Expected trigger per mode code m: 0 rise,1 fall,2/3 both,4 high,5 low
  function automatic logic exp_hit(input int m, input logic o, input logic n);
    case (m)
      0: return n & ~o;
      1: return o & ~n;
      2, 3: return o ^ n;
      4: return n;
      default: return ~n;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, meth, both, typ, ien, imsk, old, exp_raw, exp_out;
    logic [31:0] pats [9];
    pats = '{32'hFFFF_FFFF, 32'h0, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'hFFFF_0000,
             32'h0000_FFFF, 32'h1234_5678, 32'h0, 32'hFFFF_FFFF};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state and zero reads across the whole address space
    for (int a = 0; a < 256; a += 4) begin
      rd(8'(a), d);
      chk("R11 reset/undefined read", d, 32'h0);
    end
    chk("R11 reset pad_oe", pad_oe, 32'h0);
    chk("R11 reset irq", {31'h0, irq_out}, 32'h0);

    // R1..R4 output side
    wr(8'h00, 32'h1234_5678);
    rd(8'h00, d); chk("R1 data readback", d, 32'h1234_5678);
    chk("R1 pad_out", pad_out, 32'h1234_5678);
    exp_out = 32'h1234_5678;
    wr(8'h10, 32'h0000_FF00); exp_out |= 32'h0000_FF00;
    chk("R2 set", pad_out, exp_out);
    wr(8'h10, 32'h0); chk("R2 set zero no change", pad_out, exp_out);
    wr(8'h14, 32'h1200_0001); exp_out &= ~32'h1200_0001;
    chk("R3 clear", pad_out, exp_out);
    rd(8'h10, d); chk("R11 set reads zero", d, 32'h0);
    rd(8'h14, d); chk("R11 clear reads zero", d, 32'h0);
    wr(8'h08, 32'hF0F0_F0F0);
    chk("R4 pad_oe", pad_oe, 32'hF0F0_F0F0);
    rd(8'h08, d); chk("R4 dir readback", d, 32'hF0F0_F0F0);

    // R5 sync input, write ignored
    pad_in = 32'hC3C3_0F0F;
    @(posedge clk); @(negedge clk);
    rd(8'h04, d); chk("R5 one edge not yet", d, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(8'h04, d); chk("R5 after two edges", d, 32'hC3C3_0F0F);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R5 write ignored", d, 32'hC3C3_0F0F);
    pad_in = 32'h0;
    repeat (4) @(negedge clk);

    // Configure pin i with mode i%6
    meth = '0; both = '0; typ = '0;
    for (int i = 0; i < 32; i++) begin
      meth[i] = ((i % 6) >= 4);
      both[i] = ((i % 6) == 2) || ((i % 6) == 3);
      typ[i]  = ((i % 6) == 1) || ((i % 6) == 3) || ((i % 6) == 5);
    end
    ien = 32'hFFFF_00FF; imsk = 32'h00F0_00F0;
    wr(8'h34, meth); wr(8'h38, both); wr(8'h3C, typ);
    wr(8'h20, ien); wr(8'h2C, imsk);

    // R6 R7 R8 R10 sweep over pad patterns
    old = 32'h0;
    for (int p = 0; p < 9; p++) begin
      wr(8'h30, 32'hFFFF_FFFF);
      pad_in = pats[p];
      repeat (3) @(posedge clk);
      @(negedge clk);
      exp_raw = '0;
      for (int i = 0; i < 32; i++) exp_raw[i] = exp_hit(i % 6, old[i], pats[p][i]);
      rd(8'h24, d); chk("R6/R7/R8 raw status sweep", d, exp_raw);
      rd(8'h28, d); chk("R10 masked status", d, exp_raw & ien & ~imsk);
      chk("R10 irq_out", {31'h0, irq_out}, {31'h0, |(exp_raw & ien & ~imsk)});
      old = pats[p];
    end

    // R6 latency on pin 0 (rising)
    pad_in = 32'h0;
    repeat (4) @(negedge clk);
    wr(8'h30, 32'hFFFF_FFFF);
    pad_in = 32'h1;
    repeat (2) @(posedge clk); @(negedge clk);
    rd(8'h24, d); chk("R6 raw not set after two edges", {31'h0, d[0]}, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(8'h24, d); chk("R6 raw set on third edge", {31'h0, d[0]}, 32'h1);

    // R9 write-one-to-clear
    wr(8'h30, 32'h0);
    rd(8'h24, d); chk("R9 ack zero keeps bit", {31'h0, d[0]}, 32'h1);
    wr(8'h30, 32'h2);
    rd(8'h24, d); chk("R9 ack other bit keeps bit", {31'h0, d[0]}, 32'h1);
    wr(8'h30, 32'h1);
    rd(8'h24, d); chk("R9 ack clears bit", {31'h0, d[0]}, 32'h0);

    // R8 level-high pin 4: ack has no lasting effect
    pad_in = 32'h11;
    repeat (4) @(negedge clk);
    rd(8'h24, d); chk("R8 level set", {31'h0, d[4]}, 32'h1);
    wr(8'h30, 32'h10);
    rd(8'h24, d); chk("R8 ack no lasting effect", {31'h0, d[4]}, 32'h1);
    pad_in = 32'h1;
    repeat (4) @(negedge clk);
    rd(8'h24, d); chk("R8 level follows release", {31'h0, d[4]}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule